// File: doc/BRIEF.md
# Integer Execute Unit with Longword Canonicalization

This block is the arithmetic slice of an integer pipeline's execute stage. It is purely combinational. It takes a 4-bit opcode, two 64-bit operands, the current value of the destination register and a per-instruction trap-enable bit. In the same cycle it returns the value to be written, a write strobe and an overflow trap request. It handles quadword (64-bit) and longword (32-bit) add, subtract and multiply, scaled add and subtract for array indexing, the upper half of an unsigned 128-bit product, and five conditional-move variants.

Longword operations use only the low 32 bits of each operand. Their 32-bit result is sign-extended into a canonical 64-bit register image, so 32-bit and 64-bit code can mix freely without any mode switch.

The decision to trap on overflow is carried by each instruction as the `trapEn` input, and there is no global mode. When a trap is raised, the arithmetic result is still presented on `result`.

Top module: `intexec_unit`

## Requirements
- R1: Opcode 0 returns opA + opB and opcode 1 returns opA − opB, both modulo 2^64.
- R2: Opcode 2 returns the low 64 bits of the signed product opA × opB.
- R3: Opcodes 3 (add), 4 (subtract) and 5 (multiply) are longword forms. They use only bits 31..0 of each operand. The 32-bit result is placed in bits 31..0, and bits 63..31 all equal bit 31 of that result.
- R4: Opcode 10 returns bits 127..64 of the unsigned 128-bit product opA × opB.
- R5: Opcodes 6, 7, 8 and 9 return (opA<<2)+opB, (opA<<3)+opB, (opA<<2)−opB and (opA<<3)−opB respectively, modulo 2^64. These forms never flag overflow.
- R6: Opcodes 0, 1 and 2 flag overflow when the exact signed result does not fit in 64 bits.
- R7: Opcodes 3, 4 and 5 flag overflow when the exact signed result of the two signed 32-bit operands does not fit in 32 bits.
- R8: `trap` is the overflow flag ANDed with `trapEn`. When the trap fires, `result` still carries the computed value.
- R9: Opcodes 11..15 are conditional moves, tested on opA: 11 = zero, 12 = nonzero, 13 = negative, 14 = non-negative, 15 = bit 0 set. When the condition holds, `result` is opB and `writeEn` is 1. Otherwise `result` is oldDest and `writeEn` is 0. A conditional move never traps.
- R10: Every opcode from 0 to 10 drives `writeEn` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 4 | Operation select (encodings in R1–R10) |
| trapEn | input | 1 | Per-instruction overflow trap enable |
| opA | input | 64 | First operand; condition operand for moves |
| opB | input | 64 | Second operand; move source |
| oldDest | input | 64 | Current destination value |
| result | output | 64 | Value to write back |
| writeEn | output | 1 | Destination write strobe |
| trap | output | 1 | Overflow trap request |

## Verification
A vector table covers several operand classes for each opcode:
- Small positive values separate plain arithmetic from scaling mistakes.
- Operands at the signed limits tell a correctly detected overflow from a missed or spurious one, for both widths.
- Longword operands with non-zero upper halves show whether the upper bits are wrongly used.
- The all-ones operand separates unsigned from signed high products.
- Each conditional-move condition is tried both held and not held.

A random sweep mixed with boundary operands is then compared against a model written with exact 128-bit arithmetic.

// File: rtl/intexec_pkg.sv
package intexec_pkg;

  typedef enum logic [3:0] {
    OP_ADDQ   = 4'd0,
    OP_SUBQ   = 4'd1,
    OP_MULQ   = 4'd2,
    OP_ADDL   = 4'd3,
    OP_SUBL   = 4'd4,
    OP_MULL   = 4'd5,
    OP_S4ADD  = 4'd6,
    OP_S8ADD  = 4'd7,
    OP_S4SUB  = 4'd8,
    OP_S8SUB  = 4'd9,
    OP_UMULH  = 4'd10,
    OP_MOVZ   = 4'd11,
    OP_MOVNZ  = 4'd12,
    OP_MOVNEG = 4'd13,
    OP_MOVPOS = 4'd14,
    OP_MOVODD = 4'd15
  } opcode_e;

  typedef enum logic [2:0] {
    UNIT_ADD  = 3'd0,
    UNIT_SUB  = 3'd1,
    UNIT_MUL  = 3'd2,
    UNIT_MULH = 3'd3,
    UNIT_MOVE = 3'd4
  } unit_e;

  typedef enum logic [2:0] {
    COND_ZERO    = 3'd0,
    COND_NONZERO = 3'd1,
    COND_NEG     = 3'd2,
    COND_NONNEG  = 3'd3,
    COND_ODD     = 3'd4
  } cond_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    unit_e      unitSel;
    logic       isLong;
    logic [1:0] shiftAmt;
    cond_e      condSel;
    logic       ovfEligible;
  } ctrl_t;

endpackage

// File: rtl/intexec_decode.sv
module intexec_decode
  import intexec_pkg::*;
(
  input  opcode_e opcode,
  output ctrl_t   ctrl
);

  always_comb begin
    ctrl = '{unitSel: UNIT_ADD, isLong: 1'b0, shiftAmt: 2'd0,
             condSel: COND_ZERO, ovfEligible: 1'b0};
    unique case (opcode)
      OP_ADDQ:   begin ctrl.unitSel = UNIT_ADD; ctrl.ovfEligible = 1'b1; end
      OP_SUBQ:   begin ctrl.unitSel = UNIT_SUB; ctrl.ovfEligible = 1'b1; end
      OP_MULQ:   begin ctrl.unitSel = UNIT_MUL; ctrl.ovfEligible = 1'b1; end
      OP_ADDL:   begin ctrl.unitSel = UNIT_ADD; ctrl.isLong = 1'b1; ctrl.ovfEligible = 1'b1; end
      OP_SUBL:   begin ctrl.unitSel = UNIT_SUB; ctrl.isLong = 1'b1; ctrl.ovfEligible = 1'b1; end
      OP_MULL:   begin ctrl.unitSel = UNIT_MUL; ctrl.isLong = 1'b1; ctrl.ovfEligible = 1'b1; end
      OP_S4ADD:  begin ctrl.unitSel = UNIT_ADD; ctrl.shiftAmt = 2'd2; end
      OP_S8ADD:  begin ctrl.unitSel = UNIT_ADD; ctrl.shiftAmt = 2'd3; end
      OP_S4SUB:  begin ctrl.unitSel = UNIT_SUB; ctrl.shiftAmt = 2'd2; end
      OP_S8SUB:  begin ctrl.unitSel = UNIT_SUB; ctrl.shiftAmt = 2'd3; end
      OP_UMULH:  ctrl.unitSel = UNIT_MULH;
      OP_MOVZ:   begin ctrl.unitSel = UNIT_MOVE; ctrl.condSel = COND_ZERO;    end
      OP_MOVNZ:  begin ctrl.unitSel = UNIT_MOVE; ctrl.condSel = COND_NONZERO; end
      OP_MOVNEG: begin ctrl.unitSel = UNIT_MOVE; ctrl.condSel = COND_NEG;     end
      OP_MOVPOS: begin ctrl.unitSel = UNIT_MOVE; ctrl.condSel = COND_NONNEG;  end
      OP_MOVODD: begin ctrl.unitSel = UNIT_MOVE; ctrl.condSel = COND_ODD;     end
      default:   ;
    endcase
  end

endmodule

// File: rtl/intexec_datapath.sv
module intexec_datapath
  import intexec_pkg::*;
#(
  parameter int W = 64
) (
  input  ctrl_t        ctrl,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] oldDest,
  output logic [W-1:0] result,
  output logic         writeEn,
  output logic         overflow
);

  localparam int LW = W / 2;
  localparam int PW = 2 * W;

  logic [W-1:0]  aScaled, bAddend, sumRaw;
  logic          isSub, addOvfQ, addOvfL;
  logic [PW-1:0] prodSigned, prodUnsigned;
  logic [W-1:0]  prodLong;
  logic          mulOvfQ, mulOvfL;
  logic          condHold;
  logic [W-1:0]  rawResult;

  // adder shared by plain, longword and scaled forms
  always_comb begin
    isSub   = (ctrl.unitSel == UNIT_SUB);
    aScaled = opA << ctrl.shiftAmt;
    bAddend = isSub ? ~opB : opB;
    sumRaw  = aScaled + bAddend + W'(isSub);
    addOvfQ = (aScaled[W-1] == bAddend[W-1]) && (sumRaw[W-1] != aScaled[W-1]);
    addOvfL = (aScaled[LW-1] == bAddend[LW-1]) && (sumRaw[LW-1] != aScaled[LW-1]);
  end

  // multipliers: full signed, full unsigned, and longword signed
  always_comb begin
    prodSigned   = {{W{opA[W-1]}}, opA} * {{W{opB[W-1]}}, opB};
    prodUnsigned = {{W{1'b0}}, opA} * {{W{1'b0}}, opB};
    prodLong     = {{LW{opA[LW-1]}}, opA[LW-1:0]} * {{LW{opB[LW-1]}}, opB[LW-1:0]};
    mulOvfQ      = (prodSigned[PW-1:W-1] != '0) && (prodSigned[PW-1:W-1] != '1);
    mulOvfL      = (prodLong[W-1:LW-1] != '0) && (prodLong[W-1:LW-1] != '1);
  end

  always_comb begin
    unique case (ctrl.condSel)
      COND_ZERO:    condHold = (opA == '0);
      COND_NONZERO: condHold = (opA != '0);
      COND_NEG:     condHold = opA[W-1];
      COND_NONNEG:  condHold = !opA[W-1];
      COND_ODD:     condHold = opA[0];
      default:      condHold = 1'b0;
    endcase
  end

  always_comb begin
    rawResult = sumRaw;
    overflow  = 1'b0;
    writeEn   = 1'b1;
    unique case (ctrl.unitSel)
      UNIT_ADD, UNIT_SUB: begin
        rawResult = sumRaw;
        overflow  = ctrl.isLong ? addOvfL : addOvfQ;
      end
      UNIT_MUL: begin
        rawResult = ctrl.isLong ? prodLong : prodSigned[W-1:0];
        overflow  = ctrl.isLong ? mulOvfL : mulOvfQ;
      end
      UNIT_MULH: rawResult = prodUnsigned[PW-1:W];
      UNIT_MOVE: begin
        rawResult = condHold ? opB : oldDest;
        writeEn   = condHold;
      end
      default: ;
    endcase
    overflow = overflow && ctrl.ovfEligible;
  end

  // longword canonical image: upper bits copy bit LW-1
  generate
    if (W > LW) begin : g_canon
      assign result = ctrl.isLong ? {{(W-LW){rawResult[LW-1]}}, rawResult[LW-1:0]}
                                  : rawResult;
    end else begin : g_plain
      assign result = rawResult;
    end
  endgenerate

endmodule

// File: rtl/intexec_unit.sv
module intexec_unit
  import intexec_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [3:0]   opcode,
  input  logic         trapEn,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] oldDest,
  output logic [W-1:0] result,
  output logic         writeEn,
  output logic         trap
);

  ctrl_t ctrl;
  logic  overflow;

  intexec_decode u_decode (
    .opcode (opcode_e'(opcode)),
    .ctrl   (ctrl)
  );

  intexec_datapath #(.W(W)) u_datapath (
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .oldDest  (oldDest),
    .result   (result),
    .writeEn  (writeEn),
    .overflow (overflow)
  );

  assign trap = overflow & trapEn;

endmodule

// File: rtl/intexec_checker.sv
module intexec_checker #(
  parameter int W = 64
) (
  input logic [3:0]   opcode,
  input logic         trapEn,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic [W-1:0] oldDest,
  input logic [W-1:0] result,
  input logic         writeEn,
  input logic         trap
);

  localparam int LW = W / 2;

  always_comb begin
    if (!$isunknown({opcode, trapEn, opA, opB, oldDest, result, writeEn, trap})) begin
      if (opcode >= 4'd3 && opcode <= 4'd5)
        assert_canonical_R3: assert ((result[W-1:LW-1] == '0) || (result[W-1:LW-1] == '1));
      if (opcode >= 4'd6 && opcode <= 4'd9)
        assert_scaled_no_trap_R5: assert (!trap);
      if (!trapEn)
        assert_trap_gated_R8: assert (!trap);
      if (opcode >= 4'd11) begin
        assert_move_no_trap_R9: assert (!trap);
        assert_move_hold_R9: assert (writeEn || (result == oldDest));
        assert_move_take_R9: assert (!writeEn || (result == opB));
      end else begin
        assert_write_always_R10: assert (writeEn);
      end
    end
  end

endmodule

bind intexec_unit intexec_checker #(.W(W)) u_checker (
  .opcode  (opcode),
  .trapEn  (trapEn),
  .opA     (opA),
  .opB     (opB),
  .oldDest (oldDest),
  .result  (result),
  .writeEn (writeEn),
  .trap    (trap)
);

// File: tb/intexec_unit_test.sv
module intexec_unit_test;
  import intexec_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opcode = '0;
  logic        trapEn = 1'b0;
  logic [63:0] opA = '0, opB = '0, oldDest = '0;
  logic [63:0] result;
  logic        writeEn, trap;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intexec_unit uut (
    .opcode (opcode), .trapEn (trapEn), .opA (opA), .opB (opB),
    .oldDest (oldDest), .result (result), .writeEn (writeEn), .trap (trap)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] old;
    logic        te;
    logic [63:0] expRes;
    logic        expWe;
    logic        expTrap;
  } vec_t;

  localparam int NVEC = 22;
  localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  localparam vec_t VECS [NVEC] = '{
    '{4'd0,  64'd5, 64'd7, 64'd0, 1'b0, 64'd12, 1'b1, 1'b0},
    '{4'd0,  MAXP, 64'd1, 64'd0, 1'b1, MINN, 1'b1, 1'b1},
    '{4'd0,  MAXP, 64'd1, 64'd0, 1'b0, MINN, 1'b1, 1'b0},
    '{4'd1,  MINN, 64'd1, 64'd0, 1'b1, MAXP, 1'b1, 1'b1},
    '{4'd1,  64'd3, 64'd10, 64'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFF9, 1'b1, 1'b0},
    '{4'd3,  64'h7FFF_FFFF, 64'd1, 64'd0, 1'b1, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b1},
    '{4'd3,  64'hFFFF_FFFF_0000_0003, 64'h1234_5678_0000_0004, 64'd0, 1'b1, 64'd7, 1'b1, 1'b0},
    '{4'd4,  64'd0, 64'd1, 64'd0, 1'b1, ONES, 1'b1, 1'b0},
    '{4'd5,  64'h1_0000, 64'h1_0000, 64'd0, 1'b1, 64'd0, 1'b1, 1'b1},
    '{4'd5,  64'hFFFF_FFFF, 64'd5, 64'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFB, 1'b1, 1'b0},
    '{4'd2,  64'h1_0000_0000, 64'h1_0000_0000, 64'd0, 1'b1, 64'd0, 1'b1, 1'b1},
    '{4'd2,  ONES, 64'd6, 64'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFA, 1'b1, 1'b0},
    '{4'd10, ONES, ONES, 64'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 1'b0},
    '{4'd10, MINN, 64'd4, 64'd0, 1'b0, 64'd2, 1'b1, 1'b0},
    '{4'd6,  64'd3, 64'd10, 64'd0, 1'b1, 64'd22, 1'b1, 1'b0},
    '{4'd9,  64'h4000_0000_0000_0000, 64'd1, 64'd0, 1'b1, ONES, 1'b1, 1'b0},
    '{4'd11, 64'd0, 64'hAA, 64'h55, 1'b1, 64'hAA, 1'b1, 1'b0},
    '{4'd12, 64'd0, 64'hAA, 64'h55, 1'b1, 64'h55, 1'b0, 1'b0},
    '{4'd13, MINN, 64'd1, 64'h55, 1'b1, 64'd1, 1'b1, 1'b0},
    '{4'd14, ONES, 64'd1, 64'h55, 1'b1, 64'h55, 1'b0, 1'b0},
    '{4'd15, 64'd3, 64'h77, 64'h55, 1'b1, 64'h77, 1'b1, 1'b0},
    '{4'd15, 64'd2, 64'h77, 64'h55, 1'b1, 64'h55, 1'b0, 1'b0}
  };

  function automatic string resTag(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:  return "R1";
      4'd2:        return "R2";
      4'd3, 4'd4, 4'd5: return "R3";
      4'd10:       return "R4";
      4'd6, 4'd7, 4'd8, 4'd9: return "R5";
      default:     return "R9";
    endcase
  endfunction

  function automatic string trapTag(input logic [3:0] op);
    if (op <= 4'd2) return "R6 R8";
    if (op <= 4'd5) return "R7 R8";
    if (op <= 4'd9) return "R5";
    if (op == 4'd10) return "R8";
    return "R9";
  endfunction

  function automatic string weTag(input logic [3:0] op);
    return (op >= 4'd11) ? "R9" : "R10";
  endfunction

  task automatic check64(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check1(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] old, input logic te);
    @(posedge clk);
    opcode = op; opA = a; opB = b; oldDest = old; trapEn = te;
    @(negedge clk);
  endtask

  function automatic logic [127:0] sx64(input logic [63:0] v);
    return {{64{v[63]}}, v};
  endfunction

  function automatic logic [127:0] sx32(input logic [31:0] v);
    return {{96{v[31]}}, v};
  endfunction

  // exact-arithmetic reference
  task automatic model(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] old, output logic [63:0] res,
                       output logic we, output logic ovf);
    logic [127:0] f;
    logic c;
    we = 1'b1; ovf = 1'b0; res = '0; f = '0;
    case (op)
      4'd0, 4'd1, 4'd2: begin
        f = (op == 4'd0) ? sx64(a) + sx64(b) : (op == 4'd1) ? sx64(a) - sx64(b) : sx64(a) * sx64(b);
        res = f[63:0];
        ovf = (f != sx64(f[63:0]));
      end
      4'd3, 4'd4, 4'd5: begin
        f = (op == 4'd3) ? sx32(a[31:0]) + sx32(b[31:0]) :
            (op == 4'd4) ? sx32(a[31:0]) - sx32(b[31:0]) : sx32(a[31:0]) * sx32(b[31:0]);
        res = {{32{f[31]}}, f[31:0]};
        ovf = (f != sx32(f[31:0]));
      end
      4'd6: res = a * 4 + b;
      4'd7: res = a * 8 + b;
      4'd8: res = a * 4 - b;
      4'd9: res = a * 8 - b;
      4'd10: begin
        f = {64'd0, a} * {64'd0, b};
        res = f[127:64];
      end
      default: begin
        case (op)
          4'd11:   c = (a == 0);
          4'd12:   c = (a != 0);
          4'd13:   c = $signed(a) < 0;
          4'd14:   c = $signed(a) >= 0;
          default: c = a[0];
        endcase
        res = c ? b : old;
        we = c;
      end
    endcase
  endtask

  function automatic logic [63:0] pickOperand();
    case ($urandom_range(0, 5))
      0: return MAXP;
      1: return MINN;
      2: return ONES;
      3: return {{32{1'b0}}, $urandom()};
      4: return {$urandom(), 32'h7FFF_FFFF};
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] mRes;
    logic mWe, mOvf;
    repeat (3) @(posedge clk);
    // idle/reset condition: zero add gives zero, write, no trap (R1, R10, R8)
    @(negedge clk);
    check64("R1 reset", result, 64'd0);
    check1("R10 reset", writeEn, 1'b1);
    check1("R8 reset", trap, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].old, VECS[i].te);
      check64(resTag(VECS[i].op), result, VECS[i].expRes);
      check1(weTag(VECS[i].op), writeEn, VECS[i].expWe);
      check1(trapTag(VECS[i].op), trap, VECS[i].expTrap);
    end

    // R3: longword upper operand bits must not matter
    apply(4'd5, 64'hDEAD_BEEF_0000_0007, 64'h1234_0000_0000_0006, 64'd0, 1'b1);
    check64("R3 upper ignored", result, 64'd42);
    // R8: result still delivered alongside a trap
    apply(4'd1, 64'd0, MINN, 64'd0, 1'b1);
    check64("R8 result with trap", result, MINN);
    check1("R6 R8 trap", trap, 1'b1);
    // R5: scaled subtract, operands would overflow a plain add
    apply(4'd8, MAXP, MINN, 64'd0, 1'b1);
    check64("R5 scaled wrap", result, 64'h7FFF_FFFF_FFFF_FFFC);
    check1("R5 no trap", trap, 1'b0);

    for (int k = 0; k < 600; k++) begin
      logic [3:0]  op;
      logic [63:0] a, b, old;
      logic        te;
      op  = 4'($urandom_range(0, 15));
      a   = pickOperand();
      b   = pickOperand();
      old = {$urandom(), $urandom()};
      te  = 1'($urandom_range(0, 1));
      apply(op, a, b, old, te);
      model(op, a, b, old, mRes, mWe, mOvf);
      check64(resTag(op), result, mRes);
      check1(weTag(op), writeEn, mWe);
      check1(trapTag(op), trap, mOvf & te);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule